// File: doc/BRIEF.md
# Single-Channel PWM Timer Slice

This block generates one pulse-width-modulated waveform from a counter that advances on a one-cycle clock-enable pulse (`tick`). That pulse comes from a clock-select stage outside the block. An up/down counter is compared for equality against a working period value and a working duty value, and those matches set or clear an output flip-flop. A polarity input then passes either the true or the inverted flop output to the pin. The counter runs in one of two ways. In left-aligned mode it counts up and wraps. In center-aligned mode it counts up to the period value and back down, which doubles the cycle length and keeps the active pulse symmetric about the peak.

The channel enable is sampled only on `tick`, so the counter starts and stops on clock-source boundaries. Period, duty and alignment are copied into working registers in two cases: while the channel is stopped, and on the step where a running cycle returns to count zero. A write therefore never truncates a cycle that is already in progress. Because the enable waits for the next `tick`, the first cycle after enabling may start later than the write. This is permitted.

Top module: `pwm_slice`

## Requirements
- R1: While `rst_n` is low, the output flop is cleared. `pwm_out` equals the inverse of `pol_hi`.
- R2: A change on `chan_en` takes effect only at the next `tick`. Counting steps begin on the `tick` after the one that starts the channel, and every run begins at count zero.
- R3: While the channel is stopped, the counter stays at zero and the output holds the starting level (or the constant level of R8/R9). Ticks do not advance anything.
- R4: While running, the counter changes only on a clock cycle where `tick` is high.
- R5: With `center_sel`=0, a cycle lasts P ticks (counts 0..P-1). The output is at the starting level for the first D ticks and at the opposite level for the rest.
- R6: With `center_sel`=1, a cycle lasts 2P ticks (up 0..P, then down P-1..1). The output is at the starting level for the D ticks at each end of the cycle, 2D ticks in all.
- R7: The starting level is high when `pol_hi`=1 and low when `pol_hi`=0. Changing `pol_hi` inverts `pwm_out` in the same cycle.
- R8: A working duty of 0 holds `pwm_out` at the non-starting level.
- R9: A working duty that is nonzero and at or above the working period holds `pwm_out` at the starting level.
- R10: While running, new period, duty and alignment values are taken only when the counter returns to zero. While stopped, they are taken on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle clock-source enable pulse |
| chan_en | input | 1 | Channel run request |
| pol_hi | input | 1 | 1: cycle starts high; 0: cycle starts low |
| center_sel | input | 1 | 1: center-aligned counting; 0: left-aligned |
| period_in | input | 8 | Requested period value P |
| duty_in | input | 8 | Requested duty value D |
| pwm_out | output | 1 | Waveform output |

## Verification
A corrupted count or direction bit moves the next duty or period match. The error then shows on `pwm_out` as a shifted edge within one period, or within two periods in center-aligned mode. A working copy taken at the wrong moment appears as a cycle with the old and new duty mixed, which is visible at the first boundary after the write. An enable that is not synchronized shows as a waveform that starts one tick early or late, or as a restart that does not begin at count zero.

// File: rtl/pwm_slice_pkg.sv
// Shared types for the PWM slice.
package pwm_slice_pkg;
    typedef enum logic {
        ALIGN_LEFT   = 1'b0,
        ALIGN_CENTER = 1'b1
    } align_e;
endpackage

// File: rtl/pwm_en_sync.sv
// Enable synchronizer: samples the run request only on a clock-source tick,
// so counting starts and stops on source boundaries.
// Assumes tick is a single-cycle pulse.
module pwm_en_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic chan_en,
    output logic run,
    output logic step
);
    // Capture the request at each source edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run <= 1'b0;
        else if (tick)
            run <= chan_en;
    end

    // Gated clock-enable into the counter.
    assign step = tick & run;
endmodule

// File: rtl/pwm_counter.sv
// Up/down channel counter with working copies of period, duty and alignment.
// Copies reload while stopped, or on the step that returns the count to zero.
// Assumes the count never exceeds the working period (guaranteed by reload timing).
module pwm_counter
    import pwm_slice_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         step,
    input  align_e       mode_in,
    input  logic [W-1:0] per_in,
    input  logic [W-1:0] duty_in,
    output logic [W-1:0] cnt,
    output logic [W-1:0] per_w,
    output logic [W-1:0] duty_w,
    output align_e       mode_w,
    output logic [W-1:0] cnt_n,
    output logic         up_n,
    output logic [W-1:0] per_n,
    output logic [W-1:0] duty_n,
    output align_e       mode_n
);
    localparam logic [W-1:0] ONE   = W'(1);
    localparam logic [W:0]   ONE_X = (W+1)'(1);

    logic         up;
    logic         load;
    logic [W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt} + ONE_X;

    // Next count and direction for one tick step.
    always_comb begin
        cnt_n = cnt;
        up_n  = up;
        if (!run) begin
            cnt_n = '0;
            up_n  = 1'b1;
        end else if (step) begin
            if (mode_w == ALIGN_CENTER) begin
                if (up) begin
                    if (cnt >= per_w) begin
                        if (per_w <= ONE) begin
                            cnt_n = '0;
                            up_n  = 1'b1;
                        end else begin
                            cnt_n = per_w - ONE;
                            up_n  = 1'b0;
                        end
                    end else begin
                        cnt_n = cnt_inc[W-1:0];
                    end
                end else begin
                    if (cnt <= ONE) begin
                        cnt_n = '0;
                        up_n  = 1'b1;
                    end else begin
                        cnt_n = cnt - ONE;
                        up_n  = 1'b0;
                    end
                end
            end else begin
                up_n = 1'b1;
                if (cnt_inc >= {1'b0, per_w})
                    cnt_n = '0;
                else
                    cnt_n = cnt_inc[W-1:0];
            end
        end
    end

    // Reload point: stopped, or a step landing on count zero.
    assign load   = !run || (step && (cnt_n == '0));
    assign per_n  = load ? per_in  : per_w;
    assign duty_n = load ? duty_in : duty_w;
    assign mode_n = load ? mode_in : mode_w;

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            up     <= 1'b1;
            per_w  <= '0;
            duty_w <= '0;
            mode_w <= ALIGN_LEFT;
        end else begin
            cnt    <= cnt_n;
            up     <= up_n;
            per_w  <= per_n;
            duty_w <= duty_n;
            mode_w <= mode_n;
        end
    end
endmodule

// File: rtl/pwm_wave.sv
// Output flop driven by duty/period equality matches, plus the polarity mux.
// The flop holds 1 for the starting phase of a cycle. Duty 0 and
// duty >= period override the matches with constant levels.
module pwm_wave
    import pwm_slice_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         step,
    input  logic [W-1:0] cnt_n,
    input  logic         up_n,
    input  logic [W-1:0] per_n,
    input  logic [W-1:0] duty_n,
    input  align_e       mode_n,
    input  logic         pol_hi,
    output logic         pwm_out
);
    logic phase_q;
    logic phase_n;

    // Next phase from constant overrides, then from equality matches.
    always_comb begin
        phase_n = phase_q;
        if (duty_n == '0)
            phase_n = 1'b0;
        else if (duty_n >= per_n)
            phase_n = 1'b1;
        else if (!run)
            phase_n = 1'b1;
        else if (step) begin
            if (cnt_n == '0)
                phase_n = 1'b1;
            else if (cnt_n == duty_n)
                phase_n = (mode_n == ALIGN_CENTER) && !up_n;
        end
    end

    // Output flip-flop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= 1'b0;
        else
            phase_q <= phase_n;
    end

    // Polarity mux: true or inverted flop output.
    assign pwm_out = pol_hi ? phase_q : ~phase_q;
endmodule

// File: rtl/pwm_slice.sv
// Top of the PWM channel slice: enable synchronizer, counter with working
// registers, and output stage. Assumes tick comes from an external clock select.
module pwm_slice
    import pwm_slice_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         chan_en,
    input  logic         pol_hi,
    input  logic         center_sel,
    input  logic [W-1:0] period_in,
    input  logic [W-1:0] duty_in,
    output logic         pwm_out
);
    logic         run;
    logic         step;
    logic [W-1:0] cnt;
    logic [W-1:0] per_w;
    logic [W-1:0] duty_w;
    align_e       mode_w;
    logic [W-1:0] cnt_n;
    logic         up_n;
    logic [W-1:0] per_n;
    logic [W-1:0] duty_n;
    align_e       mode_n;
    align_e       mode_in;

    assign mode_in = center_sel ? ALIGN_CENTER : ALIGN_LEFT;

    pwm_en_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .chan_en (chan_en),
        .run     (run),
        .step    (step)
    );

    pwm_counter #(.W(W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .step    (step),
        .mode_in (mode_in),
        .per_in  (period_in),
        .duty_in (duty_in),
        .cnt     (cnt),
        .per_w   (per_w),
        .duty_w  (duty_w),
        .mode_w  (mode_w),
        .cnt_n   (cnt_n),
        .up_n    (up_n),
        .per_n   (per_n),
        .duty_n  (duty_n),
        .mode_n  (mode_n)
    );

    pwm_wave #(.W(W)) u_wave (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .step    (step),
        .cnt_n   (cnt_n),
        .up_n    (up_n),
        .per_n   (per_n),
        .duty_n  (duty_n),
        .mode_n  (mode_n),
        .pol_hi  (pol_hi),
        .pwm_out (pwm_out)
    );
endmodule

// File: rtl/pwm_slice_chk.sv
// Assertion checker for pwm_slice, attached by bind below.
module pwm_slice_chk
    import pwm_slice_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic         pol_hi,
    input logic         pwm_out,
    input logic         run,
    input logic [W-1:0] cnt,
    input logic [W-1:0] per_w,
    input logic [W-1:0] duty_w,
    input align_e       mode_w
);
    a_r2_run_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (run != $past(run)) |-> $past(tick));

    a_r3_stopped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));

    a_r4_tick_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(cnt));

    a_r5_left_range: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_w == ALIGN_LEFT && per_w != '0) |-> (cnt < per_w));

    a_r6_center_range: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_w == ALIGN_CENTER) |-> (cnt <= per_w));

    a_r8_duty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_w == '0) |-> (pwm_out == ~pol_hi));

    a_r9_duty_full: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_w != '0 && duty_w >= per_w) |-> (pwm_out == pol_hi));

    a_r10_reload_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(per_w) |-> (cnt == '0));
endmodule

bind pwm_slice pwm_slice_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .pol_hi  (pol_hi),
    .pwm_out (pwm_out),
    .run     (run),
    .cnt     (cnt),
    .per_w   (per_w),
    .duty_w  (duty_w),
    .mode_w  (mode_w)
);

// File: tb/sim_pwm_slice.sv
module sim_pwm_slice;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       chan_en = 1'b0;
    logic       pol_hi = 1'b1;
    logic       center_sel = 1'b0;
    logic [7:0] period_in = '0;
    logic [7:0] duty_in = '0;
    logic       pwm_out;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pwm_slice u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .chan_en(chan_en),
        .pol_hi(pol_hi), .center_sel(center_sel),
        .period_in(period_in), .duty_in(duty_in), .pwm_out(pwm_out)
    );

    // {pol, center, period, duty}
    localparam logic [17:0] VEC [8] = '{
        {1'b1, 1'b0, 8'd4, 8'd1},
        {1'b0, 1'b0, 8'd5, 8'd3},
        {1'b1, 1'b1, 8'd4, 8'd2},
        {1'b0, 1'b1, 8'd6, 8'd5},
        {1'b1, 1'b0, 8'd5, 8'd0},
        {1'b0, 1'b1, 8'd3, 8'd3},
        {1'b1, 1'b0, 8'd3, 8'd9},
        {1'b1, 1'b1, 8'd2, 8'd1}
    };

    function automatic logic exp_level(int p, int d, bit pol, bit ctr, int k);
        bit s;
        int pos;
        if (d == 0) s = 1'b0;
        else if (d >= p) s = 1'b1;
        else if (!ctr) s = ((k % p) < d);
        else begin
            pos = k % (2 * p);
            if (pos <= p) s = (pos < d);
            else s = ((2 * p - pos) <= d);
        end
        return pol ? s : !s;
    endfunction

    task automatic check(logic exp, string tag, string what);
        nchk++;
        if (pwm_out !== exp) begin
            nerr++;
            $display("FAIL %s %s: got %b expected %b", tag, what, pwm_out, exp);
        end
    endtask

    task automatic tick_once();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic start_run(bit pol, bit ctr, int p, int d);
        chan_en = 1'b0;
        tick_once();
        pol_hi = pol; center_sel = ctr;
        period_in = 8'(p); duty_in = 8'(d);
        repeat (2) @(negedge clk);
        chan_en = 1'b1;
        tick_once();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(1'b0, "R1", "reset pol=1");
        pol_hi = 1'b0;
        #1 check(1'b1, "R1", "reset pol=0");
        @(negedge clk) rst_n = 1'b1;

        // Table-driven runs
        for (int v = 0; v < 8; v++) begin
            bit pol, ctr;
            int p, d;
            string tag;
            {pol, ctr} = VEC[v][17:16];
            p = int'(VEC[v][15:8]);
            d = int'(VEC[v][7:0]);
            tag = (d == 0) ? "R8" : (d >= p) ? "R9" : ctr ? "R6" : "R5";
            start_run(pol, ctr, p, d);
            for (int k = 0; k < 20; k++) begin
                if (k > 0) tick_once();
                check(exp_level(p, d, pol, ctr, k), tag, $sformatf("vec %0d tick %0d", v, k));
            end
        end

        // R2/R3/R4: stop and restart
        start_run(1'b1, 1'b0, 4, 2);
        check(1'b1, "R2", "first tick at count 0");
        tick_once(); check(1'b1, "R5", "count 1");
        tick_once(); check(1'b0, "R5", "count 2");
        chan_en = 1'b0;
        repeat (3) @(negedge clk);
        check(1'b0, "R2", "stop not applied before tick");
        check(1'b0, "R4", "no advance without tick");
        tick_once(); check(1'b1, "R3", "stopped at starting level");
        for (int i = 0; i < 3; i++) begin
            tick_once(); check(1'b1, "R3", "ticks ignored while stopped");
        end
        chan_en = 1'b1;
        repeat (3) @(negedge clk);
        check(1'b1, "R2", "start waits for tick");
        tick_once(); check(1'b1, "R2", "restart count 0");
        tick_once(); check(1'b1, "R2", "restart count 1");
        tick_once(); check(1'b0, "R2", "restart count 2");

        // R10: duty write mid-cycle waits for boundary
        start_run(1'b1, 1'b0, 4, 1);
        check(1'b1, "R10", "k0");
        tick_once(); check(1'b0, "R10", "k1");
        duty_in = 8'd3;
        tick_once(); check(1'b0, "R10", "k2 old duty");
        tick_once(); check(1'b0, "R10", "k3 old duty");
        tick_once(); check(1'b1, "R10", "k4 new cycle");
        tick_once(); check(1'b1, "R10", "k5");
        tick_once(); check(1'b1, "R10", "k6");
        tick_once(); check(1'b0, "R10", "k7 new duty match");

        // R10/R8: while stopped, values taken at once
        chan_en = 1'b0;
        tick_once(); check(1'b1, "R3", "stopped with duty 3");
        duty_in = 8'd0;
        @(negedge clk); check(1'b0, "R10", "immediate load duty 0 (R8)");

        // R7: polarity mux acts in the same cycle
        pol_hi = 1'b0;
        #1 check(1'b1, "R7", "polarity flip");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule